// File: doc/BRIEF.md
# Byte DMA Handshake Engine

This block runs the host-side request/acknowledge handshake that moves single bytes between an external DMA controller and a byte-wide peripheral controller. A bus-side "byte ready" input says when the peripheral can take or give a byte. The engine turns that into a request to the DMA controller. Each completed host read or write strobe, made while the acknowledge is held, produces a one-cycle transfer pulse. A completed write also loads the host byte into a one-byte holding register, which the host can read on `hold_o`.

There are two pacing schemes. In per-byte mode, the request is raised for every byte and the acknowledge cycles once per byte. In held mode, the first byte is requested in the same way. After that the acknowledge stays asserted, and the `ready_o` output paces the block: it goes low after each byte and high again when the next byte is ready, which stretches the host strobe. A phase mismatch in held mode leaves `ready_o` low and raises `irq_o`. The host bus is then released only by an end-of-process input or by clearing the enable. All inputs are taken to be synchronous to `clk` and active high.

Top module: `dma_hs_engine`

## Requirements
- R1: A synchronous active-low reset forces drq_o=0, ready_o=1, irq_o=0, xfer_o=0 and hold_o=0 on the next clock edge.
- R2: With dma_en_i=1 and the engine idle, byte_rdy_i=1 raises drq_o after one clock edge, in either mode.
- R3: drq_o drops on the first clock edge at which dack_i is sampled high.
- R4: The falling end of a read or write strobe (rd_i or wr_i going low) with dack_i high, after the acknowledge has been taken, gives exactly one xfer_o pulse one cycle later. In per-byte mode drq_o is low in that cycle and stays low until byte_rdy_i is seen again.
- R5: A completed write strobe stores the data present on wdata_i while wr_i was high into hold_o. A completed read strobe leaves hold_o unchanged.
- R6: A strobe made while dack_i is low, or while no byte has been requested, produces no xfer_o pulse and leaves hold_o unchanged.
- R7: In held mode (blk_mode_i=1), ready_o goes low in the cycle of each xfer_o pulse and stays low until byte_rdy_i is seen. drq_o is not raised again within the block.
- R8: In held mode, phase_mis_i=1 during a transfer sets irq_o and holds ready_o low until eop_i or dma_en_i=0.
- R9: Taking dma_en_i low returns the engine to idle on the next edge, with ready_o=1, drq_o=0 and irq_o=0.
- R10: When eop_i is seen during a transfer, the engine stops after the current byte completes. It then keeps drq_o low and ready_o high, whatever byte_rdy_i does, until dma_en_i is cleared.
- R11: In per-byte mode, phase_mis_i=1 during a transfer sets irq_o and stops the engine with drq_o low and ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en_i | input | 1 | DMA enable; clearing it aborts and releases |
| blk_mode_i | input | 1 | 1 = held-acknowledge pacing, 0 = per-byte request |
| dack_i | input | 1 | Acknowledge from DMA controller |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| eop_i | input | 1 | End of process from DMA controller |
| byte_rdy_i | input | 1 | Bus side can move the next byte |
| phase_mis_i | input | 1 | Bus phase mismatch |
| wdata_i | input | 8 | Host write data |
| drq_o | output | 1 | DMA request |
| ready_o | output | 1 | Host strobe may complete (low extends it) |
| irq_o | output | 1 | Interrupt, latched until enable is cleared |
| xfer_o | output | 1 | One-cycle pulse per byte moved |
| hold_o | output | 8 | One-byte holding register |

## Verification
The bench sends a stray write with the acknowledge low. A design that accepted it would pulse xfer_o and corrupt hold_o. It also holds byte_rdy_i high after an end of process, where a design that ignored the stop would raise drq_o again. In held mode it checks that ready_o falls with each byte and waits for byte_rdy_i; a design that left ready_o high would let the host run ahead. After a mismatch, the bench checks that ready_o stays low across idle cycles and that only eop_i or clearing the enable brings it back.

// File: rtl/dma_hs_pkg.sv
// Shared types for the byte DMA handshake engine.
// Assumes: nothing beyond a 3-bit state encoding.
package dma_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // waiting for the bus side to be ready
        ST_REQ  = 3'd1,  // request raised, waiting for acknowledge
        ST_XFER = 3'd2,  // acknowledge taken, waiting for strobe end
        ST_WAIT = 3'd3,  // held mode: host stretched, waiting for byte
        ST_HALT = 3'd4,  // held mode: mismatch, host stretched
        ST_STOP = 3'd5   // ended by EOP or per-byte mismatch
    } hs_state_t;
endpackage

// File: rtl/dma_strobe_edge.sv
// Detects the falling end of a host read or write strobe and remembers
// whether the last strobe was a write, plus the data seen during it.
// Assumes: rd and wr are synchronous and never high together.
module dma_strobe_edge #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          stb_end_o,
    output logic          last_wr_o,
    output logic [DW-1:0] wdata_q_o
);
    logic stb_q;

    // Register the strobe level, direction and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q     <= 1'b0;
            last_wr_o <= 1'b0;
            wdata_q_o <= '0;
        end else begin
            stb_q <= rd_i | wr_i;
            if (rd_i | wr_i) last_wr_o <= wr_i;
            if (wr_i) wdata_q_o <= wdata_i;
        end
    end

    // Strobe end: it was active last cycle and is gone now.
    assign stb_end_o = stb_q & ~(rd_i | wr_i);
endmodule

// File: rtl/dma_hold_reg.sv
// One-byte holding register, loaded on a completed write transfer.
// Assumes: commit_i is a single-cycle qualified pulse.
module dma_hold_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] hold_o
);
    // Capture the byte when a write transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_o <= '0;
        else if (commit_i) hold_o <= data_i;
    end
endmodule

// File: rtl/dma_hs_fsm.sv
// Handshake sequencer: per-byte request or held-acknowledge pacing,
// with mismatch halt, EOP stop and enable abort.
// Assumes: synchronous active-high inputs; stb_end_i from the edge detector.
module dma_hs_fsm
    import dma_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic blk_mode_i,
    input  logic dack_i,
    input  logic eop_i,
    input  logic byte_rdy_i,
    input  logic phase_mis_i,
    input  logic stb_end_i,
    output logic byte_done_o,
    output logic drq_o,
    output logic ready_o,
    output logic irq_o,
    output logic xfer_o
);
    hs_state_t st, nxt;
    logic      eop_seen;
    logic      in_xfer_phase;
    logic      mis_hit;

    assign in_xfer_phase = (st == ST_REQ) || (st == ST_XFER) || (st == ST_WAIT);
    assign mis_hit       = dma_en_i && phase_mis_i && in_xfer_phase;

    // Next-state and byte-completion decode.
    always_comb begin
        nxt         = st;
        byte_done_o = 1'b0;
        if (!dma_en_i) begin
            nxt = ST_IDLE;
        end else if (mis_hit) begin
            nxt = blk_mode_i ? ST_HALT : ST_STOP;
        end else begin
            case (st)
                ST_IDLE: if (byte_rdy_i) nxt = ST_REQ;
                ST_REQ:  if (dack_i) nxt = ST_XFER;
                ST_XFER: begin
                    if (stb_end_i && dack_i) begin
                        byte_done_o = 1'b1;
                        if (eop_i || eop_seen) nxt = ST_STOP;
                        else if (blk_mode_i)   nxt = ST_WAIT;
                        else                   nxt = ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (eop_i)           nxt = ST_STOP;
                    else if (byte_rdy_i) nxt = ST_XFER;
                end
                ST_HALT: if (eop_i) nxt = ST_STOP;
                default: nxt = st;
            endcase
        end
    end

    // State, EOP latch, interrupt latch and transfer pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            eop_seen <= 1'b0;
            irq_o    <= 1'b0;
            xfer_o   <= 1'b0;
        end else begin
            st     <= nxt;
            xfer_o <= byte_done_o;
            if (!dma_en_i)                                      eop_seen <= 1'b0;
            else if (eop_i && (st == ST_REQ || st == ST_XFER))  eop_seen <= 1'b1;
            if (!dma_en_i)    irq_o <= 1'b0;
            else if (mis_hit) irq_o <= 1'b1;
        end
    end

    // Moore outputs decoded from the registered state.
    assign drq_o   = (st == ST_REQ);
    assign ready_o = !((st == ST_WAIT) || (st == ST_HALT));
endmodule

// File: rtl/dma_hs_engine.sv
// Top of the byte DMA handshake engine: joins the strobe edge detector,
// the sequencer and the holding register.
// Assumes: all inputs synchronous to clk, active high.
module dma_hs_engine #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_en_i,
    input  logic          blk_mode_i,
    input  logic          dack_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          eop_i,
    input  logic          byte_rdy_i,
    input  logic          phase_mis_i,
    input  logic [DW-1:0] wdata_i,
    output logic          drq_o,
    output logic          ready_o,
    output logic          irq_o,
    output logic          xfer_o,
    output logic [DW-1:0] hold_o
);
    logic          stb_end;
    logic          last_wr;
    logic [DW-1:0] wdata_q;
    logic          byte_done;

    dma_strobe_edge #(.DW(DW)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .stb_end_o (stb_end),
        .last_wr_o (last_wr),
        .wdata_q_o (wdata_q)
    );

    dma_hs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dma_en_i    (dma_en_i),
        .blk_mode_i  (blk_mode_i),
        .dack_i      (dack_i),
        .eop_i       (eop_i),
        .byte_rdy_i  (byte_rdy_i),
        .phase_mis_i (phase_mis_i),
        .stb_end_i   (stb_end),
        .byte_done_o (byte_done),
        .drq_o       (drq_o),
        .ready_o     (ready_o),
        .irq_o       (irq_o),
        .xfer_o      (xfer_o)
    );

    dma_hold_reg #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (byte_done & last_wr),
        .data_i   (wdata_q),
        .hold_o   (hold_o)
    );
endmodule

// File: rtl/dma_hs_checker.sv
// Temporal checks on the handshake engine ports, bound to the top.
// Assumes: reset is asserted from time zero.
module dma_hs_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_en_i,
    input logic dack_i,
    input logic eop_i,
    input logic drq_o,
    input logic ready_o,
    input logic irq_o,
    input logic xfer_o
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!drq_o && ready_o && !irq_o && !xfer_o));

    a_r3_drq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (drq_o && dack_i) |=> !drq_o);

    a_r4_no_drq_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> !drq_o);

    a_r6_pulse_needs_dack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_o) |-> $past(dack_i));

    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ready_o && dma_en_i && !eop_i) |=> (irq_o && !ready_o));

    a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> (ready_o && !drq_o && !irq_o));
endmodule

bind dma_hs_engine dma_hs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en_i (dma_en_i),
    .dack_i   (dack_i),
    .eop_i    (eop_i),
    .drq_o    (drq_o),
    .ready_o  (ready_o),
    .irq_o    (irq_o),
    .xfer_o   (xfer_o)
);

// File: tb/dma_hs_engine_bench.sv
`timescale 1ns/1ps
module dma_hs_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_en, blk, dack, rd, wr, eop, brdy, pm;
    logic [7:0] wdata;
    logic       drq, ready, irq, xfer;
    logic [7:0] hold;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    dma_hs_engine u_dma_hs_engine (
        .clk(clk), .rst_n(rst_n), .dma_en_i(dma_en), .blk_mode_i(blk),
        .dack_i(dack), .rd_i(rd), .wr_i(wr), .eop_i(eop),
        .byte_rdy_i(brdy), .phase_mis_i(pm), .wdata_i(wdata),
        .drq_o(drq), .ready_o(ready), .irq_o(irq), .xfer_o(xfer), .hold_o(hold)
    );

    // Row: [27:20] en,blk,dack,rd,wr,eop,brdy,pm  [19:12] wdata
    //      [11:8] exp drq,ready,irq,xfer          [7:0] exp hold
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        28'h0000400, // R1 idle, enable off
        28'h8200C00, // R2 byte ready raises request
        28'hA000400, // R3 acknowledge drops request
        28'hA8A5400, // write strobe high
        28'hA0005A5, // R4 R5 strobe end: pulse, byte stored
        28'h80004A5, // R4 request stays low after byte
        28'h883C4A5, // R6 stray write, acknowledge low
        28'h80004A5, // R6 no pulse, hold kept
        28'h8200CA5, // R2 next request
        28'hA0004A5, // R3 acknowledge
        28'hB0004A5, // read strobe high
        28'hA0005A5, // R5 read completes, hold unchanged
        28'h80004A5  // R4 idle again
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one control byte and data at the falling edge, settle after the rising edge.
    task automatic drv(input logic [7:0] c, input logic [7:0] wd);
        @(negedge clk);
        {dma_en, blk, dack, rd, wr, eop, brdy, pm} = c;
        wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_out(input string tag, input logic [3:0] e);
        chk(tag, {4'h0, drq, ready, irq, xfer}, {4'h0, e});
    endtask

    initial begin
        {dma_en, blk, dack, rd, wr, eop, brdy, pm} = '0;
        wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_out("R1 reset outputs", 4'h4);
        chk("R1 reset hold", hold, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drv(VEC[i][27:20], VEC[i][19:12]);
            chk_out($sformatf("R2-table row %0d outputs", i), VEC[i][11:8]);
            chk($sformatf("R5 table row %0d hold", i), hold, VEC[i][7:0]);
        end

        // R10: EOP in per-byte mode stops after the current byte.
        drv(8'h82, 8'h00); chk_out("R2 request", 4'hC);
        drv(8'hA4, 8'h00); chk_out("R10 eop with ack", 4'h4);
        drv(8'hA8, 8'h5A);
        drv(8'hA0, 8'h00); chk_out("R10 last byte pulses", 4'h5);
        chk("R10 last byte stored", hold, 8'h5A);
        drv(8'h82, 8'h00); chk_out("R10 stopped despite byte ready", 4'h4);
        drv(8'h82, 8'h00); chk_out("R10 still stopped", 4'h4);
        drv(8'h00, 8'h00); chk_out("R9 enable cleared", 4'h4);
        drv(8'h82, 8'h00); chk_out("R2 restart after clear", 4'hC);
        drv(8'h00, 8'h00);

        // R7: held mode pacing.
        drv(8'hC2, 8'h00); chk_out("R2 held first request", 4'hC);
        drv(8'hE0, 8'h00); chk_out("R3 held ack", 4'h4);
        drv(8'hE8, 8'h11);
        drv(8'hE0, 8'h00); chk_out("R7 byte done, ready low", 4'h1);
        chk("R5 held byte stored", hold, 8'h11);
        drv(8'hE0, 8'h00); chk_out("R7 ready waits for byte", 4'h0);
        drv(8'hE2, 8'h00); chk_out("R7 ready back, no request", 4'h4);
        drv(8'hE8, 8'h22);
        drv(8'hE0, 8'h00); chk_out("R7 second byte", 4'h1);
        chk("R5 second byte stored", hold, 8'h22);
        drv(8'hE2, 8'h00); chk_out("R7 ready for third", 4'h4);

        // R8: mismatch in held mode.
        drv(8'hE1, 8'h00); chk_out("R8 mismatch halts", 4'h2);
        drv(8'hE2, 8'h00); chk_out("R8 stays halted", 4'h2);
        drv(8'hE0, 8'h00); chk_out("R8 still halted", 4'h2);
        drv(8'hE4, 8'h00); chk_out("R8 eop releases ready", 4'h6);
        drv(8'h00, 8'h00); chk_out("R9 clear drops irq", 4'h4);

        // R9: clearing enable from the halt.
        drv(8'hC2, 8'h00);
        drv(8'hE0, 8'h00);
        drv(8'hE1, 8'h00); chk_out("R8 halt again", 4'h2);
        drv(8'h20, 8'h00); chk_out("R9 enable off releases", 4'h4);

        // R11: mismatch in per-byte mode.
        drv(8'h82, 8'h00); chk_out("R2 request", 4'hC);
        drv(8'h81, 8'h00); chk_out("R11 mismatch stops", 4'h6);
        drv(8'h82, 8'h00); chk_out("R11 no new request", 4'h6);
        drv(8'h00, 8'h00); chk_out("R9 clear after R11", 4'h4);

        // R6: enable off, strobes and byte ready do nothing.
        drv(8'h2A, 8'h77); chk_out("R6 disabled strobe", 4'h4);
        drv(8'h22, 8'h00); chk_out("R6 disabled no pulse", 4'h4);
        chk("R6 hold untouched", hold, 8'h22);

        // R1: reset in the middle of a request.
        drv(8'h82, 8'h00); chk_out("R2 pre-reset request", 4'hC);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk_out("R1 reset mid-request", 4'h4);
        chk("R1 reset clears hold", hold, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule